// File: doc/BRIEF.md
# Resettable Pointer Line-Delay Buffer

This block is a single-clock line store of 5120 words, 8 bits each, that serves as a delay line whose length can be programmed. A write side and a read side each keep their own address pointer. Each pointer is cleared by its own active-low clear input and moved forward by its own active-low step input. The delay between input and output is set only by how far apart in time the two pointers were cleared, and by any cycles in which one of them was held. The buffer keeps no fill count and raises no full or empty indication, because a line delay overwrites old data by design.

On the read side, the word at the read pointer is registered onto `rd_data`. A separate active-low drive control marks the output as undriven through `rd_oe`, which models a tristate bus in simulation. This control never touches the read pointer. The read pointer therefore keeps moving while the output is off, and after the output is turned back on it shows the word at the advanced position.

There is no data handshake at the edge of the block. The write side accepts a word on every edge where its step input is low. The read side cannot stall the write side. A consumer that cannot take a word holds the read pointer with `rd_en_n`, which also freezes `rd_data`. Pointer contents are undefined until each side has seen its first clear.

Top module: `line_delay_buf`

## Requirements
- R1: On a rising edge with `wr_en_n` low, `wr_data` is stored at the write address and the write pointer moves forward by one.
- R2: When `wr_rst_n` is sampled low on an edge, the write address for that edge is 0. A one-cycle pulse is enough. If `wr_en_n` is also low on that edge, the word is stored at address 0 and the next write goes to address 1.
- R3: On an edge with `wr_en_n` high, nothing is stored and the write pointer keeps its value.
- R4: On an edge with `rd_en_n` low, `rd_data` takes the word at the read address and the read pointer moves forward by one. On an edge with `rd_en_n` high, both `rd_data` and the read pointer keep their values.
- R5: When `rd_rst_n` is sampled low on an edge, the read address for that edge is 0. A one-cycle pulse is enough. If `rd_en_n` is also low on that edge, the word at address 0 is read and the next read comes from address 1.
- R6: After an edge that samples `oe_n` high, `rd_oe` is 0; after an edge that samples `oe_n` low, `rd_oe` is 1. The read pointer still follows `rd_en_n` while `rd_oe` is 0.
- R7: Both pointers wrap from address 5119 to address 0.
- R8: If both clears are applied on the same edge and both step inputs then stay low, `rd_data` after edge k+5120 equals the `wr_data` presented at edge k. A read of the address being written on the same edge returns the older word.
- R9: If the read clear follows the write clear by L edges (21 ≤ L ≤ 5120) and both step inputs stay low, `rd_data` after edge k+L equals the `wr_data` presented at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| wr_rst_n | input | 1 | Active-low write pointer clear |
| wr_en_n | input | 1 | Active-low write step; stores and advances |
| wr_data | input | 8 | Word to store |
| rd_rst_n | input | 1 | Active-low read pointer clear |
| rd_en_n | input | 1 | Active-low read step; loads output and advances |
| oe_n | input | 1 | Active-low output drive control |
| rd_data | output | 8 | Registered read word |
| rd_oe | output | 1 | 1 while the output is driven; 0 models high impedance |

## Verification
Clearing both pointers on the same edge with both steps held low exercises the full 5120-word delay and both wraps. Any off-by-one in the read-before-write order, or any error in the wrap point, shows up as a mismatch one pass later. Staggered clears at lags of 21 and 1000 show that the delay comes only from clear skew. Random step patterns on each side, taken separately, separate a write that fails to hold (R3) from a read that fails to freeze (R4). Random clears in the middle of a stream, together with random toggling of the drive control during reads, show that a clear redirects only its own edge and that turning the output off leaves the read pointer moving.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  localparam int unsigned LBUF_WIDTH_DEF = 8;
  localparam int unsigned LBUF_DEPTH_DEF = 5120;

  // Next address around a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned a, input int unsigned depth);
    return (a == depth - 1) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/lbuf_ptr.sv
module lbuf_ptr #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          step_n,
  output logic [AW-1:0] addr,
  output logic          armed
);
  logic [AW-1:0] ptr_q;

  // A clear redirects the access of its own edge to address 0.
  always_comb addr = clr_n ? ptr_q : '0;

  always_ff @(posedge clk) begin
    if (!step_n) ptr_q <= AW'(lbuf_pkg::ring_next(int'(addr), DEPTH));
    else         ptr_q <= addr;
  end

  // Marks that the pointer has been cleared at least once.
  always_ff @(posedge clk) armed <= armed | ~clr_n;

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (ptr_q == ($past(step_n) ? AW'(0) : AW'(1)))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && step_n) |=> $stable(ptr_q)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !step_n && ptr_q != AW'(DEPTH-1)) |=> (ptr_q == $past(ptr_q) + AW'(1))); // R1
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !step_n && ptr_q == AW'(DEPTH-1)) |=> (ptr_q == '0)); // R7
endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; same-address collision returns the older word.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/line_delay_buf.sv
module line_delay_buf #(
  parameter int unsigned WIDTH = lbuf_pkg::LBUF_WIDTH_DEF,
  parameter int unsigned DEPTH = lbuf_pkg::LBUF_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             wr_rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_rst_n,
  input  logic             rd_en_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0] waddr, raddr;
  logic          wr_armed, rd_armed;

  lbuf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(clk), .clr_n(wr_rst_n), .step_n(wr_en_n), .addr(waddr), .armed(wr_armed)
  );

  lbuf_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk(clk), .clr_n(rd_rst_n), .step_n(rd_en_n), .addr(raddr), .armed(rd_armed)
  );

  lbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(~wr_en_n), .waddr(waddr), .wdata(wr_data),
    .re(~rd_en_n), .raddr(raddr), .rdata(rd_data)
  );

  // Output drive flag, sampled like the other controls.
  always_ff @(posedge clk) rd_oe <= ~oe_n;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rd_armed)
    rd_en_n |=> $stable(rd_data)); // R4
  AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rd_armed)
    oe_n |=> !rd_oe); // R6
  AST_OUT_ON: assert property (@(posedge clk) disable iff (!rd_armed)
    !oe_n |=> rd_oe); // R6
  AST_WR_ARMED_STAYS: assert property (@(posedge clk) disable iff (!wr_armed)
    1'b1 |=> wr_armed); // R2
endmodule

// File: tb/line_delay_buf_test.sv
module line_delay_buf_test;
  localparam int W = 8;
  localparam int D = 5120;

  logic         clk = 1'b0;
  logic         wr_rst_n = 1'b1, wr_en_n = 1'b1, rd_rst_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_oe;

  line_delay_buf #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  logic [W-1:0] m_mem [D];
  bit           m_set [D];
  int           m_wp = 0, m_rp = 0;
  logic [W-1:0] m_dout = '0;
  bit           m_dv = 1'b0;
  bit           m_oe = 1'b0;
  logic [W-1:0] hist [D+64];

  function automatic int nxt(input int a);
    return (a == D - 1) ? 0 : a + 1;
  endfunction

  task automatic fail_line(input string tag, input int act, input int exp);
    errors++;
    $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) fail_line(tag, act, exp);
  endtask

  task automatic step(input bit wrst, input bit wen, input logic [W-1:0] d,
                      input bit rrst, input bit ren, input bit oen, input string tag);
    int ra, wa;
    wr_rst_n = wrst; wr_en_n = wen; wr_data = d;
    rd_rst_n = rrst; rd_en_n = ren; oe_n = oen;
    @(posedge clk);
    ra = rrst ? m_rp : 0;
    wa = wrst ? m_wp : 0;
    if (!ren) begin
      m_dv = m_set[ra];
      m_dout = m_mem[ra];  // read sees the word before this edge's write
      m_rp = nxt(ra);
    end else m_rp = ra;
    if (!wen) begin
      m_mem[wa] = d; m_set[wa] = 1'b1; m_wp = nxt(wa);
    end else m_wp = wa;
    m_oe = !oen;
    @(negedge clk);
    check({tag, " oe"}, int'(rd_oe), int'(m_oe));
    if (m_dv) check({tag, " data"}, int'(rd_data), int'(m_dout));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < D; i++) m_set[i] = 1'b0;
    @(negedge clk);

    // Reset state: both clears, nothing moving, output off (R6)
    step(0, 1, 8'h00, 0, 1, 1, "R6 reset-state");
    step(1, 1, 8'h00, 1, 1, 0, "R6 drive-on");

    // R8 and R7: same-edge clears, both sides free-running for more than one pass
    for (int c = 0; c < D + 64; c++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      hist[c] = d;
      step(c == 0 ? 1'b0 : 1'b1, 0, d, c == 0 ? 1'b0 : 1'b1, 0, 0, "R8 R7");
      if (c >= D) check("R8 delay", int'(rd_data), int'(hist[c - D]));
    end

    // R9: staggered clears, lag 21 then lag 1000
    for (int k = 0; k < 2; k++) begin
      int lag;
      lag = (k == 0) ? 21 : 1000;
      for (int c = 0; c < lag + 80; c++) begin
        logic [W-1:0] d;
        d = W'($urandom);
        hist[c] = d;
        step(c == 0 ? 1'b0 : 1'b1, 0, d, c == lag ? 1'b0 : 1'b1, 0, 0, "R9");
        if (c >= lag) check("R9 delay", int'(rd_data), int'(hist[c - lag]));
      end
    end

    // R3 directed: a word, a held gap with other data, a second word, then read back
    step(0, 0, 8'hA5, 0, 1, 0, "R2 R3");
    for (int i = 0; i < 4; i++) step(1, 1, 8'h3C, 1, 1, 0, "R3 hold");
    step(1, 0, 8'h5A, 1, 1, 0, "R1");
    step(1, 1, 8'h00, 0, 0, 0, "R5");
    check("R3 first", int'(rd_data), 32'hA5);
    step(1, 1, 8'h00, 1, 0, 0, "R3");
    check("R3 second", int'(rd_data), 32'h5A);

    // R1 and R3: random write steps with reads running
    for (int c = 0; c < 2000; c++)
      step(1, ($urandom % 3) == 0, W'($urandom), 1, 0, 0, "R1 R3");

    // R4: random read steps, output hold when held
    for (int c = 0; c < 2000; c++)
      step(1, 0, W'($urandom), 1, ($urandom % 2) == 0, 0, "R4");

    // R6: random drive control while reading
    for (int c = 0; c < 1500; c++)
      step(1, 0, W'($urandom), 1, ($urandom % 4) == 0, ($urandom % 2) == 0, "R6");

    // R6 directed: output off for 3 reads, then on shows the advanced word
    step(0, 0, 8'h11, 1, 1, 0, "R2");
    step(1, 0, 8'h22, 1, 1, 0, "R1");
    step(1, 0, 8'h33, 1, 1, 0, "R1");
    step(1, 0, 8'h44, 1, 1, 0, "R1");
    step(1, 1, 8'h00, 0, 0, 1, "R6 off");
    step(1, 1, 8'h00, 1, 0, 1, "R6 off");
    step(1, 1, 8'h00, 1, 0, 1, "R6 off");
    step(1, 1, 8'h00, 1, 0, 0, "R6 on");
    check("R6 advanced", int'(rd_data), 32'h44);

    // R2 and R5: random clears in the middle of random traffic
    for (int c = 0; c < 4000; c++)
      step(($urandom % 64) != 0, ($urandom % 5) == 0, W'($urandom),
           ($urandom % 64) != 0, ($urandom % 5) == 0, ($urandom % 8) == 0, "R2 R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule